// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This unit sits beside a DRAM controller and counts eight kinds of controller activity, each in its own 32-bit counter. The activity arrives as single-cycle strobes, one pin per kind. Each counter is wired to exactly one strobe, so nothing selects which event a counter sees. A counter advances only when two things are true: the global count-enable bit in the control register is set, and the counter's own bit in the event-enable register is set.

Software reaches the unit over a small register bus. A request carries a valid flag, an address, a write flag and write data. Every request is answered one cycle later with a ready pulse and registered read data. Software can preload any counter. When an increment carries a counter from all ones back to zero, the counter's overflow flag is raised. The flags, filtered by an active-high mask, are combined into one registered level interrupt. Software lowers each flag by writing a one to its bit in a separate clear register.

Top module: `mc_perf_monitor`

## Requirements
- R1: After reset, every counter, the control register, the event-enable register, the overflow status and `irq` are 0, and the interrupt mask reads 0xFF.
- R2: The counters are read and written at these addresses:
  - counters 0 to 3 at 0x380 + 4·N;
  - counters 4 to 7 at 0x3C0 + 4·(N−4).

  Counter N counts only strobe `evt_strobe[N]`, with this bit order: 0 write data beats, 1 read data beats, 2 write commands, 3 read commands, 4 precharges, 5 activates, 6 bank changes, 7 rank changes.
- R3: Counter N increments by one on a cycle where `evt_strobe[N]` is high only if control bit 1 (global enable) and event-enable bit N are both 1. The control register is at 0x010 and the event-enable register at 0x6C0. Otherwise the counter holds its value.
- R4: A write to a counter replaces its full value. If the write lands in the same cycle as an increment of that counter, the written value is kept.
- R5: Every bit of the control register other than bit 1 is plain read/write storage and has no effect on counting.
- R6: When an increment takes counter N from 0xFFFFFFFF to 0, bit N of the status register (read-only, 0x6CC) is set on that same clock edge. A software write that loads a value does not set the bit.
- R7: `irq` is a registered OR over all bits of (status AND NOT mask). The mask register is at 0x6C8, and mask bit N = 1 blocks counter N. `irq` rises one cycle after an unmasked status bit is present and stays high until no unmasked status bit remains.
- R8: Writing 1 to bit N of the clear register (0x6D0, reads 0) clears status bit N. Zero bits leave status unchanged, and writes to the status address are ignored. An overflow in the same cycle as a clear of that bit leaves the bit set.
- R9: `bus_ready` is high exactly one cycle after a cycle with `bus_valid` high. `bus_rdata` then holds the value the addressed register had before that request's own write took effect. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 8 | One-cycle event strobes, bit N feeds counter N |
| bus_valid | input | 1 | Register request valid |
| bus_we | input | 1 | Request is a write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Request completed, one cycle after `bus_valid` |
| irq | output | 1 | Level interrupt |

## Verification
A counter increment, a counter write, a status set, a clear and a register write each take effect on the edge that samples the strobe or request. Read data and `bus_ready` appear one edge after the request. `irq` follows the status and mask registers one edge later still. The bench drives every input at the falling edge and reads results at the next falling edge after the edge that produces them. Before checking `irq`, it waits one extra cycle after any write to status or mask. Each counter's value is checked only through a bus read, so the read latency is built into every counter check.

// File: rtl/mcpm_pkg.sv
package mcpm_pkg;

    localparam int NUM_CNT    = 8;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int IDX_W      = $clog2(NUM_CNT);
    localparam int GLB_EN_BIT = 1;
    localparam int HALF_CNT   = NUM_CNT / 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h010;
    localparam logic [ADDR_W-1:0] A_FLUX0  = 12'h380;
    localparam logic [ADDR_W-1:0] A_CMD0   = 12'h3C0;
    localparam logic [ADDR_W-1:0] A_EVTEN  = 12'h6C0;
    localparam logic [ADDR_W-1:0] A_MASK   = 12'h6C8;
    localparam logic [ADDR_W-1:0] A_STAT   = 12'h6CC;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 12'h6D0;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_EVTEN,
        TGT_MASK,
        TGT_STAT,
        TGT_CLEAR,
        TGT_CNT
    } reg_tgt_e;

    typedef struct packed {
        logic              valid;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        reg_tgt_e         tgt;
        logic [IDX_W-1:0] idx;
        logic             wr;
    } reg_sel_t;

    // Counters live in two groups of four, 4-byte stride each.
    function automatic logic [ADDR_W-1:0] cnt_offset(input int idx);
        if (idx < HALF_CNT)
            return A_FLUX0 + ADDR_W'(4 * idx);
        return A_CMD0 + ADDR_W'(4 * (idx - HALF_CNT));
    endfunction

endpackage

// File: rtl/mcpm_decode.sv
module mcpm_decode
    import mcpm_pkg::*;
(
    input  bus_req_t req,
    output reg_sel_t sel
);
    always_comb begin
        sel.tgt = TGT_NONE;
        sel.idx = '0;
        sel.wr  = req.valid && req.we;
        unique case (req.addr)
            A_CTRL:  sel.tgt = TGT_CTRL;
            A_EVTEN: sel.tgt = TGT_EVTEN;
            A_MASK:  sel.tgt = TGT_MASK;
            A_STAT:  sel.tgt = TGT_STAT;
            A_CLEAR: sel.tgt = TGT_CLEAR;
            default: begin
                for (int n = 0; n < NUM_CNT; n++) begin
                    if (req.addr == cnt_offset(n)) begin
                        sel.tgt = TGT_CNT;
                        sel.idx = IDX_W'(n);
                    end
                end
            end
        endcase
        if (!req.valid)
            sel.tgt = TGT_NONE;
    end
endmodule

// File: rtl/mcpm_counter.sv
module mcpm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    // A software load beats a same-cycle increment and never flags a wrap.
    assign wrap = inc && !wr && (&cnt);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (wr)
            cnt <= wdata;
        else if (inc)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mcpm_status.sv
module mcpm_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] wrap,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] drop;
    logic [N-1:0] status_d;

    assign drop     = clr_we ? clr_bits : '0;
    // Set has priority over clear for the same bit.
    assign status_d = (status & ~drop) | wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= status_d;
            irq    <= |(status & ~mask);
        end
    end
endmodule

// File: rtl/mc_perf_monitor.sv
module mc_perf_monitor
    import mcpm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        evt_strobe,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              irq
);
    bus_req_t                        req;
    reg_sel_t                        sel;
    logic [DATA_W-1:0]               ctrl_q;
    logic [NUM_CNT-1:0]              evten_q;
    logic [NUM_CNT-1:0]              mask_q;
    logic [NUM_CNT-1:0]              status_q;
    logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_q;
    logic [NUM_CNT-1:0]              cnt_wr;
    logic [NUM_CNT-1:0]              cnt_inc;
    logic [NUM_CNT-1:0]              cnt_wrap;
    logic                            clr_wr;
    logic [DATA_W-1:0]               rdata_d;

    assign req = '{valid: bus_valid, we: bus_we, addr: bus_addr, wdata: bus_wdata};

    mcpm_decode u_dec (
        .req (req),
        .sel (sel)
    );

    assign clr_wr  = sel.wr && (sel.tgt == TGT_CLEAR);
    assign cnt_inc = evt_strobe & evten_q & {NUM_CNT{ctrl_q[GLB_EN_BIT]}};

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        assign cnt_wr[n] = sel.wr && (sel.tgt == TGT_CNT) && (sel.idx == IDX_W'(n));

        mcpm_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (cnt_inc[n]),
            .wr    (cnt_wr[n]),
            .wdata (bus_wdata[CNT_W-1:0]),
            .cnt   (cnt_q[n]),
            .wrap  (cnt_wrap[n])
        );
    end

    mcpm_status #(.N(NUM_CNT)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .wrap     (cnt_wrap),
        .clr_we   (clr_wr),
        .clr_bits (bus_wdata[NUM_CNT-1:0]),
        .mask     (mask_q),
        .status   (status_q),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            evten_q <= '0;
            mask_q  <= '1;
        end else if (sel.wr) begin
            if (sel.tgt == TGT_CTRL)  ctrl_q  <= bus_wdata;
            if (sel.tgt == TGT_EVTEN) evten_q <= bus_wdata[NUM_CNT-1:0];
            if (sel.tgt == TGT_MASK)  mask_q  <= bus_wdata[NUM_CNT-1:0];
        end
    end

    always_comb begin
        rdata_d = '0;
        unique case (sel.tgt)
            TGT_CTRL:  rdata_d = ctrl_q;
            TGT_EVTEN: rdata_d = DATA_W'(evten_q);
            TGT_MASK:  rdata_d = DATA_W'(mask_q);
            TGT_STAT:  rdata_d = DATA_W'(status_q);
            TGT_CNT:   rdata_d = DATA_W'(cnt_q[sel.idx]);
            default:   rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_ready <= 1'b0;
        end else begin
            bus_rdata <= rdata_d;
            bus_ready <= bus_valid;
        end
    end
endmodule

// File: rtl/mcpm_checker.sv
module mcpm_checker
    import mcpm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           bus_valid,
    input logic                           bus_ready,
    input logic                           irq,
    input logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q,
    input logic [NUM_CNT-1:0]             cnt_wr,
    input logic [NUM_CNT-1:0]             cnt_inc,
    input logic [NUM_CNT-1:0]             status_q,
    input logic [NUM_CNT-1:0]             mask_q,
    input logic                           clr_wr,
    input logic [NUM_CNT-1:0]             clr_bits
);
    for (genvar n = 0; n < NUM_CNT; n++) begin : g_chk
        p_hold_when_off_r3: assert property (@(posedge clk) disable iff (rst)
            (!cnt_wr[n] && !cnt_inc[n]) |=> (cnt_q[n] == $past(cnt_q[n])));

        p_wrap_flags_r6: assert property (@(posedge clk) disable iff (rst)
            (!cnt_wr[n] && cnt_inc[n] && (&cnt_q[n])) |=> (status_q[n] && cnt_q[n] == '0));

        p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
            (clr_wr && clr_bits[n] && !(cnt_inc[n] && !cnt_wr[n] && (&cnt_q[n])))
            |=> !status_q[n]);
    end

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~mask_q) == '0) |=> !irq);

    p_ready_follows_r9: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> bus_ready);
endmodule

bind mc_perf_monitor mcpm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .irq       (irq),
    .cnt_q     (cnt_q),
    .cnt_wr    (cnt_wr),
    .cnt_inc   (cnt_inc),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .clr_wr    (clr_wr),
    .clr_bits  (bus_wdata[7:0])
);

// File: tb/tb_mc_perf_monitor.sv
module tb_mc_perf_monitor;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt_strobe = '0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] exp_cnt [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_perf_monitor dut (
        .clk(clk), .rst(rst), .evt_strobe(evt_strobe),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .irq(irq)
    );

    function automatic logic [11:0] caddr(input int n);
        return (n < 4) ? 12'(12'h380 + 4*n) : 12'(12'h3C0 + 4*(n-4));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        check("R9 ready", {31'b0, bus_ready}, 32'd1);
    endtask

    task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk);
        evt_strobe = m;
        @(negedge clk);
        evt_strobe = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        @(negedge clk);
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R9 idle ready", {31'b0, bus_ready}, 32'd0);
        read_check("R1 ctrl", 12'h010, 32'h0);
        read_check("R1 evten", 12'h6C0, 32'h0);
        read_check("R1 mask", 12'h6C8, 32'hFF);
        read_check("R1 status", 12'h6CC, 32'h0);
        for (int n = 0; n < 8; n++) begin
            exp_cnt[n] = '0;
            read_check("R1 counter", caddr(n), 32'h0);
        end
        read_check("R9 unmapped", 12'h004, 32'h0);
        read_check("R8 clear reads 0", 12'h6D0, 32'h0);

        // R5: storage bits of control, global enable clear
        bus_write(12'h010, 32'hA5A5_0000);
        read_check("R5 ctrl storage", 12'h010, 32'hA5A5_0000);
        bus_write(12'h6C0, 32'hFF);
        pulse(8'hFF);
        for (int n = 0; n < 8; n++)
            read_check("R5 no count with bit1 clear", caddr(n), 32'h0);

        // R2/R3: sweep global enable x local enable x counter
        for (int g = 0; g < 2; g++) begin
            for (int l = 0; l < 2; l++) begin
                for (int n = 0; n < 8; n++) begin
                    bus_write(12'h010, 32'h5A00_0000 | 32'(g << 1));
                    bus_write(12'h6C0, 32'(l << n));
                    for (int k = 0; k < 3; k++) pulse(8'hFF);
                    if (g == 1 && l == 1) exp_cnt[n] = exp_cnt[n] + 3;
                    for (int m = 0; m < 8; m++)
                        read_check("R3 R2 gated count", caddr(m), exp_cnt[m]);
                end
            end
        end
        read_check("R5 ctrl after sweep", 12'h010, 32'h5A00_0002);

        // R4: full-width load, write wins over increment
        bus_write(12'h6C0, 32'hFF);
        for (int n = 0; n < 8; n++) begin
            bus_write(caddr(n), 32'h1234_5670 + n);
            read_check("R4 load", caddr(n), 32'h1234_5670 + n);
            @(negedge clk);
            evt_strobe = 8'(1 << n);
            bus_valid = 1'b1; bus_we = 1'b1; bus_addr = caddr(n); bus_wdata = 32'hDEAD_0000 + n;
            @(negedge clk);
            evt_strobe = '0; bus_valid = 1'b0; bus_we = 1'b0;
            read_check("R4 write beats inc", caddr(n), 32'hDEAD_0000 + n);
            read_check("R6 load sets no status", 12'h6CC, 32'h0);
        end

        // R6/R7/R8: wrap, mask, clear per counter
        for (int n = 0; n < 8; n++) begin
            bus_write(12'h6C8, 32'hFF);
            bus_write(caddr(n), 32'hFFFF_FFFE);
            pulse(8'(1 << n));
            read_check("R6 no flag before wrap", 12'h6CC, 32'h0);
            pulse(8'(1 << n));
            read_check("R6 wrapped to zero", caddr(n), 32'h0);
            read_check("R6 status bit", 12'h6CC, 32'(1 << n));
            check("R7 masked irq low", {31'b0, irq}, 32'd0);
            bus_write(12'h6C8, ~32'(1 << n) & 32'hFF);
            @(negedge clk);
            check("R7 unmasked irq high", {31'b0, irq}, 32'd1);
            bus_write(12'h6CC, 32'h0);
            bus_write(12'h6D0, ~32'(1 << n) & 32'hFF);
            read_check("R8 zero bits and status write ignored", 12'h6CC, 32'(1 << n));
            check("R7 irq holds", {31'b0, irq}, 32'd1);
            bus_write(12'h6D0, 32'(1 << n));
            read_check("R8 clear", 12'h6CC, 32'h0);
            check("R7 irq drops", {31'b0, irq}, 32'd0);
        end

        // R8: overflow and clear in the same cycle keeps the bit set
        bus_write(caddr(0), 32'hFFFF_FFFF);
        @(negedge clk);
        evt_strobe = 8'h01;
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 12'h6D0; bus_wdata = 32'h01;
        @(negedge clk);
        evt_strobe = '0; bus_valid = 1'b0; bus_we = 1'b0;
        read_check("R8 set beats clear", 12'h6CC, 32'h01);
        read_check("R6 counter 0 wrapped", caddr(0), 32'h0);
        bus_write(12'h6D0, 32'h01);
        read_check("R8 final clear", 12'h6CC, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule